// File: doc/BRIEF.md
# Byte-Parallel FPGA Configuration Loader

This block sits on the configuring side of a board and loads a downstream FPGA through a byte-wide write port. It uses three handshake pins: an active-low program output, an active-low init input and a done input. A start pulse makes the loader hold program low for a fixed number of cycles and then release it. The loader then waits for the target to raise init, with an optional timeout. After that it writes a fixed header.

Raw configuration bytes come from a byte source with valid, ready and an end-of-data flag. The loader groups them into payloads of PAY_LEN bytes. Before each payload it writes a preamble code, and after it a check code and a padding sequence. Before each new frame it tests three conditions: init must be high, done must be low, and source data must remain. When the frame loop ends, the loader writes four startup fill bytes. It then records sticky success or failure flags, which stay set until the next start.

Every byte goes out as a one-cycle write strobe. The data is held steady between strobes, and there are at least GAP_CYC idle cycles between any two strobes.

Top module: `cfg_loader`

## Requirements
- R1: After reset, prog_no is high, wr_stb_o, busy_o, ok_o, fail_o, tmo_o and src_ready_o are low.
- R2: A start_i pulse while idle clears ok_o, fail_o and tmo_o, raises busy_o and drives prog_no low for exactly PROG_LOW_CYC cycles. A start_i pulse while busy has no effect on the pins or on the written stream. No write strobe occurs while prog_no is low.
- R3: No byte is written before init_ni has been sampled high after program release. If init_ni stays low for init_tmo_i consecutive cycles, the load ends with fail_o and tmo_o set and no byte written. An init_tmo_i of 0 disables the timeout.
- R4: The header written after init rises is FF FF FF 4F 80 AF 9B 4B, in that order.
- R5: Each frame is 4F, then PAY_LEN (21) payload bytes in source order, then 4B, FF, 4B, FF, FF, FF.
- R6: A new frame starts only when init_ni is high, done_i is low and the source has not yet delivered its byte flagged src_last_i. These conditions are tested at frame boundaries only, so a frame in progress always completes.
- R7: If the source's last byte falls inside a frame, the rest of that frame's payload slots are written as FF.
- R8: After the frame loop ends, for any reason, exactly four FF bytes are written and busy_o then falls.
- R9: At the end of the load, ok_o is set if done_i is high and the source's last byte was consumed; otherwise fail_o is set. The two flags are never set together.
- R10: wr_stb_o is high for one cycle per byte. wr_data_o changes only together with a strobe. Between strobes there are at least GAP_CYC idle cycles.
- R11: src_ready_o is raised only in payload slots, and each accepted source byte is the data of the next payload strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (ignored while busy) |
| init_tmo_i | input | TMO_W | Init wait limit in cycles, 0 = no limit |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Sticky: last load succeeded |
| fail_o | output | 1 | Sticky: last load failed |
| tmo_o | output | 1 | Sticky: last load failed on init timeout |
| prog_no | output | 1 | Program pin to target, active low |
| init_ni | input | 1 | Init pin from target, active low |
| done_i | input | 1 | Done pin from target |
| wr_stb_o | output | 1 | One-cycle byte write strobe |
| wr_data_o | output | 8 | Byte to write, stable between strobes |
| src_valid_i | input | 1 | Source byte available |
| src_data_i | input | 8 | Source byte |
| src_last_i | input | 1 | Source byte is the final one |
| src_ready_o | output | 1 | Loader takes the source byte this cycle |

## Verification
The bench compares every strobe against an expected stream built from the source contents. A loop decision taken in the wrong state shows as an extra or missing frame. That surfaces at the first strobe of the following frame, or when the startup bytes begin. A payload index that is off by one shifts the 4B check code, and the miscompare appears within one frame. Errors in the status flags or the end-of-data flag are visible once busy_o falls. Drift in the program-pulse or pacing counters appears at the program rise or at the next strobe.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WAIT, S_HDR, S_CHK, S_PRE, S_PAY, S_TAIL, S_STUP, S_FIN
  } state_e;

  typedef enum logic [1:0] {SEQ_HDR, SEQ_TAIL, SEQ_STUP} seq_e;

  localparam logic [7:0] BYTE_FILL = 8'hFF;
  localparam logic [7:0] BYTE_PRE  = 8'h4F;
  localparam logic [7:0] BYTE_CHK  = 8'h4B;
  localparam int HDR_LEN  = 8;
  localparam int TAIL_LEN = 6;
  localparam int STUP_LEN = 4;
endpackage

// File: rtl/cfg_code_rom.sv
module cfg_code_rom
  import cfg_loader_pkg::*;
(
  input  seq_e       seq_i,
  input  logic [2:0] idx_i,
  output logic [7:0] byte_o
);
  always_comb begin
    byte_o = BYTE_FILL;
    unique case (seq_i)
      SEQ_HDR: begin
        unique case (idx_i)
          3'd3:    byte_o = BYTE_PRE;
          3'd4:    byte_o = 8'h80;
          3'd5:    byte_o = 8'hAF;
          3'd6:    byte_o = 8'h9B;
          3'd7:    byte_o = BYTE_CHK;
          default: byte_o = BYTE_FILL;
        endcase
      end
      SEQ_TAIL: byte_o = (idx_i == 3'd0 || idx_i == 3'd2) ? BYTE_CHK : BYTE_FILL;
      default:  byte_o = BYTE_FILL;
    endcase
  end
endmodule

// File: rtl/cfg_pacer.sv
module cfg_pacer #(
  parameter int GAP_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic ready_o
);
  generate
    if (GAP_CYC == 0) begin : g_free
      assign ready_o = 1'b1;
    end else begin : g_gap
      localparam int GW = $clog2(GAP_CYC + 1);
      logic [GW-1:0] gap_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            gap_q <= '0;
        else if (fire_i)        gap_q <= GW'(GAP_CYC);
        else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
      end
      assign ready_o = (gap_q == '0);
    end
  endgenerate
endmodule

// File: rtl/cfg_cnt.sv
module cfg_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (inc_i)  q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int PROG_LOW_CYC = 2000,
  parameter int GAP_CYC      = 1,
  parameter int PAY_LEN      = 21,
  parameter int TMO_W        = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TMO_W-1:0] init_tmo_i,
  output logic             busy_o,
  output logic             ok_o,
  output logic             fail_o,
  output logic             tmo_o,
  output logic             prog_no,
  input  logic             init_ni,
  input  logic             done_i,
  output logic             wr_stb_o,
  output logic [7:0]       wr_data_o,
  input  logic             src_valid_i,
  input  logic [7:0]       src_data_i,
  input  logic             src_last_i,
  output logic             src_ready_o
);
  localparam int PCW   = (PROG_LOW_CYC > 1) ? $clog2(PROG_LOW_CYC) : 1;
  localparam int CNT_W = (PCW > TMO_W) ? PCW : TMO_W;
  localparam int PIW   = $clog2(PAY_LEN);
  localparam int IDX_W = (PIW > 3) ? PIW : 3;

  state_e             state_q;
  logic [IDX_W-1:0]   idx_q;
  logic               eod_q;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic               cnt_clr, cnt_inc, prog_last, tmo_hit;
  logic               pace_rdy, emit, take, idx_last;
  seq_e               seq;
  logic [7:0]         rom_byte, byte_nx;

  cfg_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .inc_i(cnt_inc), .q_o(cnt_q)
  );

  cfg_pacer #(.GAP_CYC(GAP_CYC)) u_pace (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(emit), .ready_o(pace_rdy)
  );

  cfg_code_rom u_rom (.seq_i(seq), .idx_i(idx_q[2:0]), .byte_o(rom_byte));

  assign cnt_nx    = cnt_q + 1'b1;
  assign prog_last = (cnt_q == CNT_W'(PROG_LOW_CYC - 1));
  assign tmo_hit   = (init_tmo_i != '0) && (cnt_nx >= CNT_W'(init_tmo_i));

  always_comb begin
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      S_PROG: begin cnt_clr = prog_last; cnt_inc = !prog_last; end
      S_WAIT: begin cnt_clr = init_ni;   cnt_inc = !init_ni;   end
      default: cnt_clr = 1'b1;
    endcase
  end

  always_comb begin
    seq      = SEQ_HDR;
    emit     = 1'b0;
    take     = 1'b0;
    byte_nx  = BYTE_FILL;
    idx_last = 1'b0;
    unique case (state_q)
      S_HDR: begin
        emit = pace_rdy; byte_nx = rom_byte;
        idx_last = (idx_q == IDX_W'(HDR_LEN - 1));
      end
      S_PRE: begin emit = pace_rdy; byte_nx = BYTE_PRE; end
      S_PAY: begin
        emit     = pace_rdy && (eod_q || src_valid_i);
        take     = emit && !eod_q;
        byte_nx  = eod_q ? BYTE_FILL : src_data_i;
        idx_last = (idx_q == IDX_W'(PAY_LEN - 1));
      end
      S_TAIL: begin
        seq = SEQ_TAIL; emit = pace_rdy; byte_nx = rom_byte;
        idx_last = (idx_q == IDX_W'(TAIL_LEN - 1));
      end
      S_STUP: begin
        seq = SEQ_STUP; emit = pace_rdy; byte_nx = rom_byte;
        idx_last = (idx_q == IDX_W'(STUP_LEN - 1));
      end
      default: ;
    endcase
  end

  assign src_ready_o = (state_q == S_PAY) && pace_rdy && !eod_q;
  assign busy_o      = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      eod_q     <= 1'b0;
      prog_no   <= 1'b1;
      ok_o      <= 1'b0;
      fail_o    <= 1'b0;
      tmo_o     <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= emit;
      if (emit) wr_data_o <= byte_nx;
      if (take && src_last_i) eod_q <= 1'b1;
      if (emit) idx_q <= idx_last ? '0 : idx_q + 1'b1;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_PROG;
          prog_no <= 1'b0;
          ok_o    <= 1'b0;
          fail_o  <= 1'b0;
          tmo_o   <= 1'b0;
          eod_q   <= 1'b0;
          idx_q   <= '0;
        end
        S_PROG: if (prog_last) begin
          prog_no <= 1'b1;
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (init_ni) begin
            state_q <= S_HDR;
            idx_q   <= '0;
          end else if (tmo_hit) begin
            fail_o  <= 1'b1;
            tmo_o   <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_HDR:  if (emit && idx_last) state_q <= S_CHK;
        S_CHK: begin
          idx_q   <= '0;
          state_q <= (init_ni && !done_i && !eod_q) ? S_PRE : S_STUP;
        end
        S_PRE:  if (emit) begin state_q <= S_PAY; idx_q <= '0; end
        S_PAY:  if (emit && idx_last) state_q <= S_TAIL;
        S_TAIL: if (emit && idx_last) state_q <= S_CHK;
        S_STUP: if (emit && idx_last) state_q <= S_FIN;
        S_FIN:  if (pace_rdy) begin
          ok_o    <= done_i && eod_q;
          fail_o  <= !(done_i && eod_q);
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int GAP_CYC = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       ok_o,
  input logic       fail_o,
  input logic       tmo_o,
  input logic       prog_no,
  input logic       done_i,
  input logic       wr_stb_o,
  input logic [7:0] wr_data_o,
  input logic       src_ready_o
);
  p_quiet_in_prog_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> !wr_stb_o);

  p_single_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && (GAP_CYC > 0)) |=> !wr_stb_o);

  p_data_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_o |-> $stable(wr_data_o));

  p_excl_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && fail_o));

  p_tmo_is_fail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> fail_o);

  p_ok_needs_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(done_i));

  p_ready_when_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> busy_o);

  p_idle_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !wr_stb_o);
endmodule

bind cfg_loader cfg_loader_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o),
  .tmo_o(tmo_o), .prog_no(prog_no), .done_i(done_i), .wr_stb_o(wr_stb_o),
  .wr_data_o(wr_data_o), .src_ready_o(src_ready_o)
);

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
  localparam int P  = 5;
  localparam int G  = 2;
  localparam int PL = 21;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [TW-1:0] init_tmo_i = '0;
  logic busy_o, ok_o, fail_o, tmo_o, prog_no, wr_stb_o, src_ready_o;
  logic init_ni = 1'b0;
  logic done_i = 1'b0;
  logic [7:0] wr_data_o;
  logic src_valid_i, src_last_i;
  logic [7:0] src_data_i;

  logic [7:0] src_mem [0:63];
  int src_n = 0, src_ptr = 0, cyc = 0;
  bit stall_en = 1'b0;
  int nchk = 0, nfail = 0;
  logic [7:0] exp_q[$];
  int nstb = 0, idle_run = 1000, low_run = 0;
  int init_delay = 0, init_cnt = -1, done_at = -1, fall_at = -1;
  logic [7:0] last_data = 8'h00;

  always #2.5 clk = ~clk;

  assign src_valid_i = (src_ptr < src_n) && !(stall_en && (cyc % 3 == 0));
  assign src_data_i  = (src_ptr < src_n) ? src_mem[src_ptr] : 8'h00;
  assign src_last_i  = (src_ptr == src_n - 1);

  cfg_loader #(.PROG_LOW_CYC(P), .GAP_CYC(G), .PAY_LEN(PL), .TMO_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .init_tmo_i(init_tmo_i),
    .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o), .tmo_o(tmo_o),
    .prog_no(prog_no), .init_ni(init_ni), .done_i(done_i),
    .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o),
    .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_last_i(src_last_i),
    .src_ready_o(src_ready_o)
  );

  task automatic chk(input bit cond, input string req, input int act, input int expv);
    nchk++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_ready_o && src_valid_i) src_ptr <= src_ptr + 1;
  end

  // target model and stream comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!prog_no) begin
        low_run++;
        init_ni  = 1'b0;
        done_i   = 1'b0;
        init_cnt = init_delay;
      end else begin
        if (low_run > 0) begin
          chk(low_run == P, "R2 program pulse width", low_run, P);
          low_run = 0;
        end
        if (init_cnt > 0) init_cnt--;
        else if (init_cnt == 0) begin init_ni = 1'b1; init_cnt = -1; end
      end
      if (wr_stb_o) begin
        nstb++;
        chk(idle_run >= G, "R10 strobe spacing", idle_run, G);
        chk(init_ni === 1'b1 || nstb > 8, "R3 write before init", init_ni, 1);
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected strobe", wr_data_o, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(wr_data_o == e, "R5 stream byte", wr_data_o, e);
        end
        idle_run  = 0;
        last_data = wr_data_o;
        if (nstb == done_at) done_i = 1'b1;
        if (nstb == fall_at) begin init_ni = 1'b0; init_cnt = -1; end
      end else begin
        idle_run++;
        if (wr_data_o != last_data) chk(1'b0, "R10 data held", wr_data_o, last_data);
      end
    end
  end

  always @(posedge clk) if (cyc > 150000) begin
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  task automatic build(input int n, input int frames);
    logic [7:0] hdr [0:7];
    hdr = '{8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
    exp_q.delete();
    for (int i = 0; i < 8; i++) exp_q.push_back(hdr[i]);  // R4
    for (int f = 0; f < frames; f++) begin
      exp_q.push_back(8'h4F);
      for (int k = 0; k < PL; k++) begin
        int ix;
        ix = f * PL + k;
        exp_q.push_back(ix < n ? src_mem[ix] : 8'hFF);     // R7 padding
      end
      exp_q.push_back(8'h4B); exp_q.push_back(8'hFF); exp_q.push_back(8'h4B);
      exp_q.push_back(8'hFF); exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
    end
    for (int i = 0; i < 4; i++) exp_q.push_back(8'hFF);   // R8
  endtask

  task automatic run(input string name, input int n, input int frames, input int idel,
                     input int tmo, input int d_at, input int f_at, input bit stall,
                     input bit poke, input bit exp_ok, input bit exp_tmo);
    int guard, used;
    @(negedge clk);
    src_ptr = 0;
    src_n = n;
    for (int i = 0; i < 64; i++) src_mem[i] = 8'((i * 37 + 5) & 255);
    stall_en   = stall;
    init_tmo_i = TW'(tmo);
    init_delay = idel;
    done_at    = d_at;
    fall_at    = f_at;
    nstb       = 0;
    idle_run   = 1000;
    if (exp_tmo) exp_q.delete();
    else build(n, frames);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {"R2 busy after start ", name}, busy_o, 1);
    chk(!ok_o && !fail_o && !tmo_o, {"R2 status cleared ", name}, {ok_o, fail_o, tmo_o}, 0);
    if (poke) begin
      repeat (100) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      chk(prog_no == 1'b1, "R2 start while busy ignored", prog_no, 1);
    end
    guard = 0;
    while (busy_o && guard < 20000) begin @(negedge clk); guard++; end
    chk(!busy_o, {"R8 load finished ", name}, busy_o, 0);
    chk(ok_o == exp_ok, {"R9 ok flag ", name}, ok_o, exp_ok);
    chk(fail_o == !exp_ok, {"R9 fail flag ", name}, fail_o, !exp_ok);
    chk(tmo_o == exp_tmo, {"R3 timeout flag ", name}, tmo_o, exp_tmo);
    chk(exp_q.size() == 0, {"R6 stream length ", name}, exp_q.size(), 0);
    used = (n < frames * PL) ? n : frames * PL;
    chk(src_ptr == used, {"R11 bytes consumed ", name}, src_ptr, used);
    if (exp_tmo) chk(nstb == 0, "R3 no write on timeout", nstb, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(prog_no == 1'b1, "R1 prog high", prog_no, 1);
    chk(!wr_stb_o && !busy_o && !src_ready_o, "R1 quiet", {wr_stb_o, busy_o, src_ready_o}, 0);
    chk(!ok_o && !fail_o && !tmo_o, "R1 status low", {ok_o, fail_o, tmo_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // two full frames, success; a start while busy is ignored (R2, R5, R9)
    run("two_frames", 42, 2, 10, 0, 8 + 2 * 28 + 1, -1, 1'b0, 1'b1, 1'b1, 1'b0);
    // exactly one frame, loop ends on empty source (R6)
    run("one_frame", 21, 1, 3, 50, 8 + 28 + 1, -1, 1'b0, 1'b0, 1'b1, 1'b0);
    // short last frame with stalls, timeout disabled, done never rises (R7, R3, R9)
    run("short_tail", 30, 2, 60, 0, -1, -1, 1'b1, 1'b0, 1'b0, 1'b0);
    // init never rises, timeout of 20 cycles (R3)
    run("init_tmo", 42, 0, -1, 20, -1, -1, 1'b0, 1'b0, 1'b0, 1'b1);
    // done rises early, loop stops after current frame (R6, R9)
    run("early_done", 42, 1, 4, 0, 20, -1, 1'b0, 1'b0, 1'b0, 1'b0);
    // init falls during first frame (R6, R8)
    run("init_drop", 42, 1, 4, 0, -1, 20, 1'b0, 1'b0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule